// File: doc/BRIEF.md
# Nested Stream Index Counter

This block watches a valid-qualified sample stream and attaches to every accepted sample the position it holds inside a set of nested loops. The innermost loop counts polarization (two values), the middle loop counts samples belonging to one beamlet, and the outermost loop counts beamlets. Each level has its own start, exclusive stop and step, all fixed by parameters. A valid sample moves the innermost level forward. An outer level moves only when every level inside it wraps on that same sample.

Next to the raw counts, the block builds a read address for a weight memory. In that memory the two polarizations of one beamlet sit side by side: even words hold the first polarization and odd words hold the second. The address therefore carries the polarization count in bit 0 and the low bits of the beamlet count above it. With the default sizes, beamlet 87 lands on words 174 and 175. Downstream logic uses the address, the counts and a delayed copy of the sample together. All of them come from one register stage, so they stay aligned.

Top module: `nest_idx_tagger`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid is 0 and out_count, out_addr and out_data are all zero. The first sample accepted after reset is tagged with every level at its start value.
- R2: The innermost level (polarization, out_count bits CNT_W-1:0) steps from its start by its step value. On the sample where count+step would reach or pass its stop, it returns to its start.
- R3: A level above the innermost one advances by its step only on a valid sample where every lower level wraps. On any other sample it keeps its value, and it wraps to its start by the same rule as R2.
- R4: A cycle with in_valid low changes no count. The next valid sample continues the sequence, and out_count and out_addr keep their last values while out_valid is 0.
- R5: out_valid equals in_valid delayed by exactly one clock cycle.
- R6: When out_valid is 1, out_data equals the in_data presented with the sample one cycle earlier.
- R7: When out_valid is 1, out_count holds the level values as they stood before the producing sample advanced them. Level k occupies bits k*CNT_W +: CNT_W.
- R8: When out_valid is 1, out_addr bit 0 equals bit 0 of the polarization count (level 0), and out_addr bits BEAM_BITS:1 equal the low BEAM_BITS bits of the beamlet count (outermost level).
- R9: After a whole period of samples, which is the product of all level lengths, every level returns to its start on the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe of the reference input stream |
| in_data | input | DATA_W | Sample payload, passed through |
| out_valid | output | 1 | Delayed sample strobe |
| out_data | output | DATA_W | Delayed sample payload |
| out_count | output | NUM_LEVELS*CNT_W | Index tag for each level, level 0 in the low bits |
| out_addr | output | BEAM_BITS+1 | Interleaved weight-memory read address |

## Verification
The bench builds the block with 8-bit counts and three short levels. The polarization level runs from 0 to 1 with step 1. The middle level starts at 1 and steps by 2 below a stop of 7, giving 1, 3 and 5. The beamlet level counts 0 to 4. The full nest then repeats every 30 samples, so a few hundred cycles cover several complete periods, including the simultaneous wrap of all levels. The nonzero start and the step of 2 exercise the start/stop/step arithmetic that the default all-zero-start, unit-step setting would hide. Streams with gaps and a reset in mid-period check hold behaviour and restart.

// File: rtl/nest_idx_pkg.sv
package nest_idx_pkg;
  // Level that feeds address bit 0 (fastest loop).
  localparam int unsigned NIDX_POL_LEVEL = 0;
  // Number of flops in the reset release synchronizer.
  localparam int unsigned NIDX_RST_STAGES = 2;

  typedef enum logic {
    NIDX_KEEP = 1'b0,
    NIDX_MOVE = 1'b1
  } nidx_adv_e;
endpackage

// File: rtl/nest_idx_rst_sync.sv
module nest_idx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nest_idx_level.sv
module nest_idx_level
  import nest_idx_pkg::*;
#(
  parameter int unsigned      CNT_W = 20,
  parameter logic [CNT_W-1:0] START = '0,
  parameter logic [CNT_W-1:0] STOP  = 2,
  parameter logic [CNT_W-1:0] STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  nidx_adv_e        adv,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;

  // One extra bit so the stop comparison cannot overflow.
  always_comb begin
    sum     = {1'b0, cnt_q} + {1'b0, STEP};
    at_last = (sum >= {1'b0, STOP});
    cnt_d   = cnt_q;
    if (adv == NIDX_MOVE) begin
      if (at_last) cnt_d = START;
      else         cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= START;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/nest_idx_tag_reg.sv
module nest_idx_tag_reg
  import nest_idx_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 3,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BEAM_BITS  = 7,
  localparam int unsigned TAG_W     = NUM_LEVELS*CNT_W,
  localparam int unsigned ADDR_W    = BEAM_BITS+1,
  localparam int unsigned BEAM_LSB  = (NUM_LEVELS-1)*CNT_W,
  localparam int unsigned POL_LSB   = NIDX_POL_LEVEL*CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  cnt_flat,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_count,
  output logic [ADDR_W-1:0] out_addr
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] adr_q, adr_d;

  always_comb begin
    vld_d = in_valid;
    dat_d = dat_q;
    tag_d = tag_q;
    adr_d = adr_q;
    if (in_valid) begin
      dat_d = in_data;
      tag_d = cnt_flat;
      adr_d = {cnt_flat[BEAM_LSB +: BEAM_BITS], cnt_flat[POL_LSB]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      tag_q <= '0;
      adr_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      tag_q <= tag_d;
      adr_q <= adr_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_count = tag_q;
  assign out_addr  = adr_q;
endmodule

// File: rtl/nest_idx_tagger.sv
module nest_idx_tagger
  import nest_idx_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 3,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BEAM_BITS  = 7,
  parameter logic [NUM_LEVELS*CNT_W-1:0] LVL_START = '0,
  parameter logic [NUM_LEVELS*CNT_W-1:0] LVL_STOP  = {20'd88, 20'd100, 20'd2},
  parameter logic [NUM_LEVELS*CNT_W-1:0] LVL_STEP  = {20'd1, 20'd1, 20'd1},
  localparam int unsigned TAG_W  = NUM_LEVELS*CNT_W,
  localparam int unsigned ADDR_W = BEAM_BITS+1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_count,
  output logic [ADDR_W-1:0] out_addr
);
  logic                  rst_sync_n;
  logic [NUM_LEVELS:0]   carry;
  logic [NUM_LEVELS-1:0] last;
  logic [TAG_W-1:0]      cnt_flat;

  nest_idx_rst_sync #(.STAGES(NIDX_RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Carry ripples outward: level k moves when all inner levels wrap.
  assign carry[0] = in_valid;

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
    nidx_adv_e adv;
    assign adv        = carry[k] ? NIDX_MOVE : NIDX_KEEP;
    assign carry[k+1] = carry[k] & last[k];

    nest_idx_level #(
      .CNT_W (CNT_W),
      .START (LVL_START[k*CNT_W +: CNT_W]),
      .STOP  (LVL_STOP [k*CNT_W +: CNT_W]),
      .STEP  (LVL_STEP [k*CNT_W +: CNT_W])
    ) u_level (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .adv     (adv),
      .cnt     (cnt_flat[k*CNT_W +: CNT_W]),
      .at_last (last[k])
    );
  end

  logic unused_carry;
  assign unused_carry = carry[NUM_LEVELS];

  nest_idx_tag_reg #(
    .NUM_LEVELS (NUM_LEVELS),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .BEAM_BITS  (BEAM_BITS)
  ) u_tag_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cnt_flat  (cnt_flat),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_count (out_count),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/nest_idx_checker.sv
module nest_idx_checker #(
  parameter int unsigned NUM_LEVELS = 3,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BEAM_BITS  = 7,
  parameter logic [NUM_LEVELS*CNT_W-1:0] LVL_STOP = '1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [DATA_W-1:0]           in_data,
  input logic                        out_valid,
  input logic [DATA_W-1:0]           out_data,
  input logic [NUM_LEVELS*CNT_W-1:0] out_count,
  input logic [BEAM_BITS:0]          out_addr
);
  localparam int unsigned BEAM_LSB = (NUM_LEVELS-1)*CNT_W;

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r5_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_data_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data == $past(in_data)));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_count) && $stable(out_addr)));
  a_r2_pol_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count[CNT_W-1:0] < LVL_STOP[CNT_W-1:0]));
  a_r8_addr_matches_tag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_addr[0] == out_count[0]) &&
                   (out_addr[BEAM_BITS:1] == out_count[BEAM_LSB +: BEAM_BITS])));
endmodule

bind nest_idx_tagger nest_idx_checker #(
  .NUM_LEVELS (NUM_LEVELS),
  .CNT_W      (CNT_W),
  .DATA_W     (DATA_W),
  .BEAM_BITS  (BEAM_BITS),
  .LVL_STOP   (LVL_STOP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_count (out_count),
  .out_addr  (out_addr)
);

// File: tb/nest_idx_tagger_bench.sv
`timescale 1ns/1ps
module nest_idx_tagger_bench;
  localparam int NL = 3;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int BB = 3;
  localparam int TW = NL*CW;
  localparam logic [TW-1:0] STARTS = {8'd0, 8'd1, 8'd0};
  localparam logic [TW-1:0] STOPS  = {8'd5, 8'd7, 8'd2};
  localparam logic [TW-1:0] STEPS  = {8'd1, 8'd2, 8'd1};

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [TW-1:0] out_count;
  logic [BB:0]   out_addr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int cur   [NL];
  int exp_tag [NL];
  int last_tag [NL];
  bit exp_valid;
  int exp_data;
  int samples_since_rst;

  nest_idx_tagger #(
    .NUM_LEVELS (NL), .CNT_W (CW), .DATA_W (DW), .BEAM_BITS (BB),
    .LVL_START (STARTS), .LVL_STOP (STOPS), .LVL_STEP (STEPS)
  ) u_nest_idx_tagger (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
    .out_valid (out_valid), .out_data (out_data),
    .out_count (out_count), .out_addr (out_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int fld(logic [TW-1:0] v, int k);
    return int'(v[k*CW +: CW]);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NL; k++) begin
      cur[k] = fld(STARTS, k);
      last_tag[k] = 0;
    end
    exp_valid = 0;
    exp_data  = 0;
    samples_since_rst = 0;
  endtask

  // Compare outputs against the prediction made on the previous drive.
  task automatic check_outputs();
    check("R5 out_valid", int'(out_valid), int'(exp_valid));
    if (exp_valid) begin
      check("R6 out_data", int'(out_data), exp_data);
      check("R7 R2 level0 tag", fld(out_count, 0), exp_tag[0]);
      check("R7 R3 level1 tag", fld(out_count, 1), exp_tag[1]);
      check("R7 R3 level2 tag", fld(out_count, 2), exp_tag[2]);
      check("R8 out_addr", int'(out_addr),
            ((exp_tag[2] % (1 << BB)) * 2) + (exp_tag[0] % 2));
      if (samples_since_rst == 1)
        check("R1 first tag at starts", int'(out_count), int'(STARTS));
      if (samples_since_rst > 1 && (samples_since_rst - 1) % 30 == 0)
        check("R9 full period wrap", int'(out_count), int'(STARTS));
      for (int k = 0; k < NL; k++) last_tag[k] = exp_tag[k];
    end else begin
      check("R4 counts held", int'(out_count),
            last_tag[0] | (last_tag[1] << CW) | (last_tag[2] << (2*CW)));
      check("R4 addr held", int'(out_addr),
            ((last_tag[2] % (1 << BB)) * 2) + (last_tag[0] % 2));
    end
  endtask

  task automatic cycle(bit v, int d);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_data  = DW'(d);
    exp_valid = v;
    if (v) begin
      bit carry = 1;
      exp_data = d % 256;
      samples_since_rst++;
      for (int k = 0; k < NL; k++) exp_tag[k] = cur[k];
      for (int k = 0; k < NL; k++) begin
        if (carry) begin
          if (cur[k] + fld(STEPS, k) >= fld(STOPS, k)) cur[k] = fld(STARTS, k);
          else begin cur[k] = cur[k] + fld(STEPS, k); carry = 0; end
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset count", int'(out_count), 0);
    check("R1 reset addr", int'(out_addr), 0);
    check("R1 reset data", int'(out_data), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) cycle(1'b0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    model_reset();
    for (int k = 0; k < NL; k++) exp_tag[k] = 0;
    do_reset();
    // Continuous stream: more than two full periods.
    for (int i = 0; i < 70; i++) cycle(1'b1, i*7 + 3);
    // Gapped stream, R4 idle holds.
    for (int i = 0; i < 90; i++) cycle((i % 3) != 1, i*5 + 1);
    // Reset in mid-period, then restart (R1).
    for (int i = 0; i < 13; i++) cycle(1'b1, i + 100);
    do_reset();
    for (int i = 0; i < 80; i++) cycle((i % 2) == 0 || (i % 7) == 3, 255 - i);
    for (int i = 0; i < 3; i++) cycle(1'b0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule